// File: doc/BRIEF.md
# Group-Aware Interrupt Line Selector

This block sits on the processor side of an interrupt controller. A distributor offers it the most urgent pending interrupt, with that interrupt's ID, security group and priority. The block also watches the processor's current exception level and security state. From these it decides whether the interrupt may be delivered at all, and if so on which of the two request lines, `irq_o` or `fiq_o`. Three security groups share those two lines, and the line chosen depends on the state the processor is in at the time. A fast request therefore says nothing, on its own, about whether the source is secure.

Delivery is gated in two places. A priority mask sets a threshold, and the processor's own I and F mask bits block their lines. When the processor acknowledges, the block returns the ID of the interrupt it is signalling, or a spurious ID if there is nothing to deliver. In the same cycle it consumes the offer from the distributor.

The distributor side is a valid/ready stream. The distributor raises `pend_valid_i` and holds ID, group and priority stable until it sees `pend_ready_i` high at a clock edge. It may change or withdraw an offer that has not been accepted. `pend_ready_o` is high only in a cycle where an acknowledge is requested and the offer is deliverable, so back-pressure lasts for as long as the processor does not acknowledge. The acknowledge request and its response are plain single-cycle pulses.

Top module: `irq_fiq_sel`

## Requirements
- R1: A group 0 interrupt (group code 0) is always signalled on `fiq_o`, whatever the security state or exception level.
- R2: A secure group 1 interrupt (group code 1) is signalled on `irq_o` when the processor is secure (`cpu_ns_i`=0) at exception level 0, 1 or 2. It is signalled on `fiq_o` when the processor is non-secure or at exception level 3.
- R3: A non-secure group 1 interrupt (group code 2) is signalled on `irq_o` when the processor is non-secure below exception level 3. It is signalled on `fiq_o` when the processor is secure or at exception level 3.
- R4: Exception level 0 never takes interrupts itself. At level 0 the line chosen is the one chosen at level 1 in the same security state.
- R5: An interrupt is signalled only when its priority value is numerically lower than `pmr_i`. An equal or larger value gives no request.
- R6: `mask_i_i`=1 suppresses `irq_o` and `mask_f_i`=1 suppresses `fiq_o`. A masked interrupt is never moved to the other line.
- R7: At most one of `irq_o` and `fiq_o` is high. Both are registered and follow their inputs one clock later.
- R8: When `ack_req_i` is high and the offer is deliverable, `pend_ready_o` is high in that cycle. One cycle later `ack_valid_o` pulses with `ack_id_o` equal to the offered ID.
- R9: When `ack_req_i` is high and nothing is deliverable, `pend_ready_o` stays low. One cycle later `ack_valid_o` pulses with `ack_id_o` = 1023.
- R10: In the cycle after an accepted acknowledge, both request lines are low, even if the distributor keeps offering.
- R11: Group code 3 is reserved. Such an offer is never signalled and never accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_valid_i | input | 1 | Distributor offers an interrupt |
| pend_ready_o | output | 1 | Offer accepted by an acknowledge this cycle |
| pend_id_i | input | 10 | Offered interrupt ID |
| pend_grp_i | input | 2 | Group: 0 group 0, 1 secure group 1, 2 non-secure group 1, 3 reserved |
| pend_prio_i | input | 8 | Priority value, lower is more urgent |
| pmr_i | input | 8 | Priority mask threshold |
| cpu_el_i | input | 2 | Current exception level 0..3 |
| cpu_ns_i | input | 1 | 1 when the processor is non-secure |
| mask_i_i | input | 1 | Processor I mask bit |
| mask_f_i | input | 1 | Processor F mask bit |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| ack_req_i | input | 1 | Processor acknowledge request |
| ack_valid_o | output | 1 | Acknowledge response pulse |
| ack_id_o | output | 10 | Acknowledged ID or 1023 |

## Verification
The bench covers all three groups in both security states at levels 0 through 3. A wrong routing table shows up as the request on the wrong line, most visibly at level 3 and at level 0. It checks a priority exactly equal to the mask and one just below it, which catches an off-by-one comparison. It also checks a masked line, where a faulty design would reroute to the other line. For acknowledges, it confirms that the line drops while the offer is still held and that an undeliverable offer returns 1023 without being consumed. A design that got these wrong would keep a request up after acknowledge or swallow an interrupt that was never delivered.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'd0,
    GRP_G1S  = 2'd1,
    GRP_G1NS = 2'd2,
    GRP_RSVD = 2'd3
  } grp_e;

  typedef enum logic {
    LINE_IRQ = 1'b0,
    LINE_FIQ = 1'b1
  } line_e;
endpackage

// File: rtl/grp_line_map.sv
module grp_line_map
  import irq_sel_pkg::*;
#(
  parameter int EL_W = 2
) (
  input  logic [1:0]      grp_i,
  input  logic            cpu_ns_i,
  input  logic [EL_W-1:0] cpu_el_i,
  output line_e           line_o,
  output logic            legal_o
);
  localparam logic [EL_W-1:0] EL_TOP = {EL_W{1'b1}};

  logic at_top;
  assign at_top = (cpu_el_i == EL_TOP);

  // Level 0 is handled like level 1: only security state and top level matter.
  always_comb begin
    legal_o = 1'b1;
    line_o  = LINE_FIQ;
    unique case (grp_e'(grp_i))
      GRP_G0:   line_o = LINE_FIQ;
      GRP_G1S:  line_o = (!cpu_ns_i && !at_top) ? LINE_IRQ : LINE_FIQ;
      GRP_G1NS: line_o = (cpu_ns_i && !at_top) ? LINE_IRQ : LINE_FIQ;
      default: begin
        legal_o = 1'b0;
        line_o  = LINE_FIQ;
      end
    endcase
  end
endmodule

// File: rtl/prio_gate.sv
module prio_gate
  import irq_sel_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              valid_i,
  input  logic              legal_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] pmr_i,
  input  line_e             line_i,
  input  logic              mask_i_i,
  input  logic              mask_f_i,
  output logic              deliver_o
);
  logic above_mask;
  logic line_open;

  assign above_mask = (prio_i < pmr_i);
  assign line_open  = (line_i == LINE_FIQ) ? !mask_f_i : !mask_i_i;
  assign deliver_o  = valid_i && legal_i && above_mask && line_open;
endmodule

// File: rtl/ack_unit.sv
module ack_unit #(
  parameter int          ID_W    = 10,
  parameter logic [ID_W-1:0] SPUR_ID = 10'd1023
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ack_req_i,
  input  logic            deliver_i,
  input  logic [ID_W-1:0] pend_id_i,
  output logic            take_o,
  output logic            ack_valid_o,
  output logic [ID_W-1:0] ack_id_o
);
  assign take_o = ack_req_i && deliver_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid_o <= 1'b0;
      ack_id_o    <= SPUR_ID;
    end else begin
      ack_valid_o <= ack_req_i;
      if (ack_req_i) ack_id_o <= deliver_i ? pend_id_i : SPUR_ID;
    end
  end

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_i |=> ack_valid_o);
  assert_spurious_id_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req_i && !deliver_i) |=> (ack_id_o == SPUR_ID));
  assert_no_stray_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req_i |=> !ack_valid_o);
endmodule

// File: rtl/irq_fiq_sel.sv
module irq_fiq_sel
  import irq_sel_pkg::*;
#(
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  parameter int EL_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend_valid_i,
  output logic              pend_ready_o,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic [1:0]        pend_grp_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] pmr_i,
  input  logic [EL_W-1:0]   cpu_el_i,
  input  logic              cpu_ns_i,
  input  logic              mask_i_i,
  input  logic              mask_f_i,
  output logic              irq_o,
  output logic              fiq_o,
  input  logic              ack_req_i,
  output logic              ack_valid_o,
  output logic [ID_W-1:0]   ack_id_o
);
  localparam logic [ID_W-1:0] SPUR_ID = ID_W'(1023);

  line_e line;
  logic  legal;
  logic  deliver;
  logic  take;

  grp_line_map #(.EL_W(EL_W)) u_map (
    .grp_i    (pend_grp_i),
    .cpu_ns_i (cpu_ns_i),
    .cpu_el_i (cpu_el_i),
    .line_o   (line),
    .legal_o  (legal)
  );

  prio_gate #(.PRIO_W(PRIO_W)) u_gate (
    .valid_i   (pend_valid_i),
    .legal_i   (legal),
    .prio_i    (pend_prio_i),
    .pmr_i     (pmr_i),
    .line_i    (line),
    .mask_i_i  (mask_i_i),
    .mask_f_i  (mask_f_i),
    .deliver_o (deliver)
  );

  ack_unit #(.ID_W(ID_W), .SPUR_ID(SPUR_ID)) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_req_i   (ack_req_i),
    .deliver_i   (deliver),
    .pend_id_i   (pend_id_i),
    .take_o      (take),
    .ack_valid_o (ack_valid_o),
    .ack_id_o    (ack_id_o)
  );

  assign pend_ready_o = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= deliver && !take && (line == LINE_IRQ);
      fiq_o <= deliver && !take && (line == LINE_FIQ);
    end
  end

  assert_single_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));
  assert_group0_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(pend_grp_i) != 2'd0));
  assert_prio_below_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> ($past(pend_prio_i) < $past(pmr_i)));
  assert_irq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> !$past(mask_i_i));
  assert_fiq_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> !$past(mask_f_i));
  assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready_o |=> (!irq_o && !fiq_o));
  assert_reserved_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o || fiq_o) |-> ($past(pend_grp_i) != 2'd3));
  assert_accept_needs_offer_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pend_ready_o |-> (pend_valid_i && ack_req_i && pend_grp_i != 2'd3));
endmodule

// File: tb/irq_fiq_sel_test.sv
module irq_fiq_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pend_valid = 1'b0;
  logic       pend_ready;
  logic [9:0] pend_id = '0;
  logic [1:0] pend_grp = '0;
  logic [7:0] pend_prio = '0;
  logic [7:0] pmr = '0;
  logic [1:0] cpu_el = '0;
  logic       cpu_ns = 1'b0;
  logic       mask_i = 1'b0;
  logic       mask_f = 1'b0;
  logic       irq, fiq;
  logic       ack_req = 1'b0;
  logic       ack_valid;
  logic [9:0] ack_id;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_fiq_sel uut (
    .clk(clk), .rst_n(rst_n),
    .pend_valid_i(pend_valid), .pend_ready_o(pend_ready),
    .pend_id_i(pend_id), .pend_grp_i(pend_grp), .pend_prio_i(pend_prio),
    .pmr_i(pmr), .cpu_el_i(cpu_el), .cpu_ns_i(cpu_ns),
    .mask_i_i(mask_i), .mask_f_i(mask_f),
    .irq_o(irq), .fiq_o(fiq),
    .ack_req_i(ack_req), .ack_valid_o(ack_valid), .ack_id_o(ack_id)
  );

  // fields: req(4) grp(2) ns(1) el(2) prio(8) pmr(8) mi(1) mf(1) eirq(1) efiq(1)
  localparam int NV = 21;
  localparam logic [28:0] VEC [NV] = '{
    {4'd1, 2'd0, 1'b0, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd1, 2'd0, 1'b1, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd1, 2'd0, 1'b0, 2'd3, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd2, 2'd1, 1'b0, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd2, 2'd1, 1'b1, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd2, 2'd1, 1'b0, 2'd3, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd2, 2'd1, 1'b0, 2'd2, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd3, 2'd2, 1'b1, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd3, 2'd2, 1'b0, 2'd1, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd3, 2'd2, 1'b0, 2'd3, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd3, 2'd2, 1'b1, 2'd2, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd4, 2'd2, 1'b1, 2'd0, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd4, 2'd1, 1'b0, 2'd0, 8'h40, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd4, 2'd2, 1'b0, 2'd0, 8'h40, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1},
    {4'd5, 2'd2, 1'b1, 2'd1, 8'h80, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd5, 2'd2, 1'b1, 2'd1, 8'h7F, 8'h80, 1'b0, 1'b0, 1'b1, 1'b0},
    {4'd5, 2'd0, 1'b0, 2'd3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6, 2'd2, 1'b1, 2'd1, 8'h40, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0},
    {4'd6, 2'd2, 1'b1, 2'd1, 8'h40, 8'h80, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd6, 2'd0, 1'b0, 2'd1, 8'h40, 8'h80, 1'b0, 1'b1, 1'b0, 1'b0},
    {4'd11, 2'd3, 1'b1, 2'd1, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic string req_name(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state
    check("R7", "reset irq", {31'd0, irq}, 32'd0);
    check("R7", "reset fiq", {31'd0, fiq}, 32'd0);
    check("R8", "reset ack_valid", {31'd0, ack_valid}, 32'd0);
    rst_n = 1'b1;
    cycle();

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      pend_valid = 1'b1;
      pend_id    = 10'(i + 5);
      pend_grp   = v[24:23];
      cpu_ns     = v[22];
      cpu_el     = v[21:20];
      pend_prio  = v[19:12];
      pmr        = v[11:4];
      mask_i     = v[3];
      mask_f     = v[2];
      cycle();
      check(req_name(v[28:25]), $sformatf("vector %0d lines {irq,fiq}", i),
            {30'd0, irq, fiq}, {30'd0, v[1], v[0]});
    end

    // Acknowledge of a delivered interrupt: R8, R10
    pend_valid = 1'b1; pend_id = 10'h2A; pend_grp = 2'd2; cpu_ns = 1'b1;
    cpu_el = 2'd1; pend_prio = 8'h10; pmr = 8'hF0; mask_i = 1'b0; mask_f = 1'b0;
    cycle();
    check("R7", "irq before ack", {31'd0, irq}, 32'd1);
    ack_req = 1'b1;
    #1;
    check("R8", "pend_ready in ack cycle", {31'd0, pend_ready}, 32'd1);
    cycle();
    ack_req = 1'b0;
    check("R8", "ack_valid", {31'd0, ack_valid}, 32'd1);
    check("R8", "ack_id", {22'd0, ack_id}, 32'h2A);
    check("R10", "lines after ack {irq,fiq}", {30'd0, irq, fiq}, 32'd0);
    cycle();
    check("R8", "ack_valid single pulse", {31'd0, ack_valid}, 32'd0);
    check("R7", "held offer reasserts", {31'd0, irq}, 32'd1);

    // Nothing pending: R9
    pend_valid = 1'b0;
    ack_req = 1'b1;
    #1;
    check("R9", "pend_ready with no offer", {31'd0, pend_ready}, 32'd0);
    cycle();
    ack_req = 1'b0;
    check("R9", "ack_valid spurious", {31'd0, ack_valid}, 32'd1);
    check("R9", "ack_id spurious", {22'd0, ack_id}, 32'd1023);

    // Offer masked on its own line: R9, R6
    pend_valid = 1'b1; pend_id = 10'h055; pend_grp = 2'd0; mask_f = 1'b1;
    ack_req = 1'b1;
    #1;
    check("R9", "pend_ready masked offer", {31'd0, pend_ready}, 32'd0);
    cycle();
    ack_req = 1'b0;
    check("R9", "ack_id masked offer", {22'd0, ack_id}, 32'd1023);
    check("R6", "no reroute to irq", {31'd0, irq}, 32'd0);

    // Reserved group never accepted: R11
    mask_f = 1'b0; pend_grp = 2'd3; pend_id = 10'h0AA;
    ack_req = 1'b1;
    #1;
    check("R11", "pend_ready reserved", {31'd0, pend_ready}, 32'd0);
    cycle();
    ack_req = 1'b0;
    check("R11", "ack_id reserved", {22'd0, ack_id}, 32'd1023);

    // Group 0 fast request at level 0 non-secure, then ack: R1, R8
    pend_grp = 2'd0; cpu_el = 2'd0; cpu_ns = 1'b1; pend_id = 10'h3FE;
    cycle();
    check("R1", "group 0 at level 0 {irq,fiq}", {30'd0, irq, fiq}, 32'd1);
    ack_req = 1'b1;
    cycle();
    ack_req = 1'b0;
    check("R8", "ack_id group 0", {22'd0, ack_id}, 32'h3FE);
    check("R10", "fiq after ack", {31'd0, fiq}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule